// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block counts down from a programmed reload value at a low tick rate. It derives that tick from a slow-clock strobe through a fixed divider. Software must restart it before it runs out. A restart is only honoured when the command carries the right key byte and the count has already fallen to or below a programmed window limit. An early restart or a badly keyed command is treated as a fault, just like running out. Either fault sets a sticky status flag and can raise a one-cycle reset request toward the system reset controller.

The configuration register can be written exactly once after reset, which locks the timeout, the window, the reset enable, the debug-halt enable and the disable bit. The status register reports the sticky flags and clears them when read. A read-only count register exposes the live counter. The reset input is asserted asynchronously and released through an internal synchronizer.

Top module: `wdw_top`

## Requirements
- R1: After reset, the configuration reads back with the reload value and the window limit at all ones, reset enable (bit 12) set, debug-halt enable (bit 13) clear and disable (bit 15) clear. The count register (address 3) reads all ones, status (address 2) reads 0, and fault_o and rst_req_o are low.
- R2: While the block is running, the counter drops by one once every PRESC_DIV cycles in which slow_en is high. Cycles with slow_en low do not advance the divider.
- R3: When a tick arrives with the counter at zero, the counter reloads from the reload field, status bit 0 (underflow) is set, and rst_req_o pulses for one cycle if reset enable is set.
- R4: A write to address 0 with bit 0 set, bits [31:24] equal to 0x5A and the count at or below the window limit reloads the counter and clears the divider. A window limit of all ones allows the restart at any count.
- R5: A write to address 0 with a wrong key, or a keyed restart while the count is above the window limit, leaves the counter unchanged. It sets status bit 1 (error) and pulses rst_req_o if reset enable is set. A keyed write with bit 0 clear has no effect.
- R6: The first write to address 1 after reset stores reload [CNT_W-1:0], reset enable [12], debug-halt enable [13], disable [15] and window limit [16+CNT_W-1:16]. It also loads the counter with the new reload value. Every later write to address 1 is ignored until the next reset.
- R7: With disable set, the counter holds, writes to address 0 have no effect, and rst_req_o stays low.
- R8: With debug-halt enable set, the counter and the divider hold while dbg_halt_i is high. With the enable clear, dbg_halt_i is ignored.
- R9: Reading address 2 clears both status flags, unless a new event arrives in the same cycle. fault_o is high whenever either flag is set.
- R10: With reset enable clear, underflow and error still set their flags, but rst_req_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle strobe per slow-clock period |
| dbg_halt_i | input | 1 | Debugger halt indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status when reading address 2) |
| addr | input | 2 | Register address: 0 command, 1 configuration, 2 status, 3 count |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| rst_req_o | output | 1 | One-cycle watchdog reset request |
| fault_o | output | 1 | High while any sticky flag is set |

## Verification
The bench sweeps a restart across every count between the reload value and zero. A window comparison that was off by one, or inverted, would then accept an early restart or flag a legal one at the boundary. It sweeps the number of slow strobes after a restart, and this exposes a divider that wraps one strobe early or late, or that is not cleared by the restart. The bench also writes the configuration a second time, expecting a design that failed to lock to reload the counter and change the readback. It runs out the counter with reset enable clear and with disable set, where a faulty gate would still raise a reset request.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 2;

  localparam logic [ADDR_W-1:0] ADDR_CMD    = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd3;

  localparam logic [7:0] CMD_KEY   = 8'h5A;
  localparam int KEY_LSB           = 24;
  localparam int RESTART_BIT       = 0;

  localparam int CFG_RELOAD_LSB    = 0;
  localparam int CFG_RSTEN_BIT     = 12;
  localparam int CFG_HALTEN_BIT    = 13;
  localparam int CFG_DIS_BIT       = 15;
  localparam int CFG_WIN_LSB       = 16;

  localparam int ST_UF_BIT         = 0;
  localparam int ST_ERR_BIT        = 1;
endpackage

// File: rtl/wdw_prescaler.sv
module wdw_prescaler #(
  parameter int PRESC_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow_en,
  input  logic clr,
  output logic tick
);
  localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] div_q, div_d;
  logic          adv;

  assign adv = run && slow_en && !clr;

  always_comb begin
    div_d = div_q;
    tick  = 1'b0;
    if (clr) begin
      div_d = '0;
    end else if (adv) begin
      if (div_q == LAST) begin
        div_d = '0;
        tick  = 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clr || adv) begin
      div_q <= div_d;
    end
  end

  a_r2_tick_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (div_q == '0));
  a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(div_q));
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             uf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign uf_evt = tick && !load && (cnt_q == '0);
  assign upd    = load || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      cnt_d = (cnt_q == '0) ? reload : (cnt_q - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_MAX;
    end else if (upd) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r3_reload_on_uf: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/wdw_regs.sv
module wdw_regs
  import wdw_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              uf_evt,
  input  logic              err_evt,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  win,
  output logic              rst_en,
  output logic              halt_en,
  output logic              dis,
  output logic              cfg_load,
  output logic              restart_cmd,
  output logic              badkey_cmd,
  output logic              uf_flag,
  output logic              err_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] reload_q, win_q;
  logic             rsten_q, halten_q, dis_q, locked_q;
  logic             uf_q, uf_d, err_q, err_d;
  logic             wr_cmd, key_ok, rd_status;

  assign wr_cmd      = wr_en && (addr == ADDR_CMD);
  assign key_ok      = (wdata[KEY_LSB +: 8] == CMD_KEY);
  assign restart_cmd = wr_cmd && key_ok && wdata[RESTART_BIT];
  assign badkey_cmd  = wr_cmd && !key_ok;
  assign cfg_load    = wr_en && (addr == ADDR_CFG) && !locked_q;
  assign rd_status   = rd_en && (addr == ADDR_STATUS);

  // configuration register: single accepted write per reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= CNT_MAX;
      win_q    <= CNT_MAX;
      rsten_q  <= 1'b1;
      halten_q <= 1'b0;
      dis_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (cfg_load) begin
      reload_q <= wdata[CFG_RELOAD_LSB +: CNT_W];
      win_q    <= wdata[CFG_WIN_LSB +: CNT_W];
      rsten_q  <= wdata[CFG_RSTEN_BIT];
      halten_q <= wdata[CFG_HALTEN_BIT];
      dis_q    <= wdata[CFG_DIS_BIT];
      locked_q <= 1'b1;
    end
  end

  // sticky flags, set wins over clear-on-read
  always_comb begin
    uf_d  = uf_q;
    err_d = err_q;
    if (rd_status) begin
      uf_d  = 1'b0;
      err_d = 1'b0;
    end
    if (uf_evt)  uf_d  = 1'b1;
    if (err_evt) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (rd_status || uf_evt || err_evt) begin
      uf_q  <= uf_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CFG: begin
        rdata[CFG_RELOAD_LSB +: CNT_W] = reload_q;
        rdata[CFG_WIN_LSB +: CNT_W]    = win_q;
        rdata[CFG_RSTEN_BIT]           = rsten_q;
        rdata[CFG_HALTEN_BIT]          = halten_q;
        rdata[CFG_DIS_BIT]             = dis_q;
      end
      ADDR_STATUS: begin
        rdata[ST_UF_BIT]  = uf_q;
        rdata[ST_ERR_BIT] = err_q;
      end
      ADDR_COUNT: rdata[CNT_W-1:0] = cnt;
      default:    rdata = '0;
    endcase
  end

  assign reload   = reload_q;
  assign win      = win_q;
  assign rst_en   = rsten_q;
  assign halt_en  = halten_q;
  assign dis      = dis_q;
  assign uf_flag  = uf_q;
  assign err_flag = err_q;

  a_r6_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && addr == ADDR_CFG)
      |=> ($stable(reload_q) && $stable(win_q) && $stable(dis_q)
           && $stable(rsten_q) && $stable(halten_q)));
  a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !uf_evt && !err_evt) |=> (!uf_q && !err_q));
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_q);
  a_r3_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> uf_q);
endmodule

// File: rtl/wdw_top.sv
module wdw_top
  import wdw_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PRESC_DIV   = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_en,
  input  logic              dbg_halt_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req_o,
  output logic              fault_o
);
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_int_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync_q <= '0;
        else        rsync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync_q <= '0;
        else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_int_n = rsync_q[SYNC_STAGES-1];

  logic [CNT_W-1:0] reload, win, cnt, load_val;
  logic rst_en, halt_en, dis, cfg_load, restart_cmd, badkey_cmd;
  logic uf_flag, err_flag, uf_evt, err_evt, tick, run;
  logic in_window, good_restart, load, req_d, req_q;

  assign run          = !dis && !(halt_en && dbg_halt_i);
  assign in_window    = (cnt <= win);
  assign good_restart = !dis && restart_cmd && in_window;
  assign err_evt      = !dis && (badkey_cmd || (restart_cmd && !in_window));
  assign load         = cfg_load || good_restart;
  assign load_val     = cfg_load ? wdata[CFG_RELOAD_LSB +: CNT_W] : reload;
  assign req_d        = rst_en && !dis && (uf_evt || err_evt);

  wdw_regs #(.CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .uf_evt(uf_evt), .err_evt(err_evt), .rdata(rdata),
    .reload(reload), .win(win), .rst_en(rst_en), .halt_en(halt_en), .dis(dis),
    .cfg_load(cfg_load), .restart_cmd(restart_cmd), .badkey_cmd(badkey_cmd),
    .uf_flag(uf_flag), .err_flag(err_flag)
  );

  wdw_prescaler #(.PRESC_DIV(PRESC_DIV)) i_presc (
    .clk(clk), .rst_n(rst_int_n), .run(run), .slow_en(slow_en),
    .clr(load), .tick(tick)
  );

  wdw_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .load(load),
    .load_val(load_val), .reload(reload), .cnt(cnt), .uf_evt(uf_evt)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) req_q <= 1'b0;
    else            req_q <= req_d;
  end

  assign rst_req_o = req_q;
  assign fault_o   = uf_flag || err_flag;

  a_r10_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_req_o |-> $past(rst_en));
  a_r7_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_req_o |-> !$past(dis));
  a_r7_frozen_disabled: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dis && !cfg_load) |=> $stable(cnt));
  a_r4_restart_reloads: assert property (@(posedge clk) disable iff (!rst_int_n)
    (good_restart && !cfg_load) |=> (cnt == $past(reload)));
  a_r9_fault_tracks_flags: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(fault_o) |-> $past(uf_evt || err_evt));
endmodule

// File: tb/test_wdw_top.sv
module test_wdw_top;
  localparam int CW  = 5;
  localparam int DIV = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_en = 1'b0, dbg_halt_i = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rst_req_o, fault_o;

  int checks = 0, failures = 0, nreq = 0, cyc = 0;

  wdw_top #(.CNT_W(CW), .PRESC_DIV(DIV)) i_wdw_top (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .dbg_halt_i(dbg_halt_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rst_req_o(rst_req_o), .fault_o(fault_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_req_o === 1'b1) nreq <= nreq + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_en = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); slow_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg(input int rl, input int wn, input bit re,
                                      input bit he, input bit ds);
    return (32'(wn) << 16) | (32'(ds) << 15) | (32'(he) << 13) | (32'(re) << 12) | 32'(rl);
  endfunction

  localparam logic [31:0] RESTART = 32'h5A00_0001;

  initial begin : watchdog
    wait (cyc > 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int ec, base;
    do_reset();

    // R1 reset state
    chk("R1 fault", fault_o, 0);
    rd(2'd1, v); chk("R1 cfg", v, cfg(MAXC, MAXC, 1, 0, 0));
    rd(2'd3, v); chk("R1 count", v, MAXC);
    rd(2'd2, v); chk("R1 status", v, 0);
    chk("R1 req", nreq, 0);

    // R2/R4 divider sweep, full window allows restart anywhere
    for (int k = 0; k <= 40; k++) begin
      wr(2'd0, RESTART);
      pulse(k);
      rd(2'd3, v); chk("R2 divide", v, MAXC - k / DIV);
    end
    rd(2'd2, v); chk("R4 no error full window", v, 0);

    // R8 halt input ignored when enable clear
    dbg_halt_i = 1'b1;
    wr(2'd0, RESTART); pulse(8);
    rd(2'd3, v); chk("R8 ignored", v, MAXC - 2);
    dbg_halt_i = 1'b0;

    // R3 underflow
    base = nreq;
    wr(2'd0, RESTART); pulse(DIV * (MAXC + 1));
    rd(2'd3, v); chk("R3 reload", v, MAXC);
    chk("R9 fault on", fault_o, 1);
    rd(2'd2, v); chk("R3 uf flag", v, 1);
    chk("R3 req", nreq - base, 1);
    rd(2'd2, v); chk("R9 cleared", v, 0);
    chk("R9 fault off", fault_o, 0);

    // R5 keys
    base = nreq;
    wr(2'd0, 32'h0000_0001);
    rd(2'd2, v); chk("R5 bad key flag", v, 2);
    chk("R5 bad key req", nreq - base, 1);
    rd(2'd3, v); chk("R5 count kept", v, MAXC);
    wr(2'd0, 32'h5A00_0000);
    rd(2'd2, v); chk("R5 keyed no-op", v, 0);

    // R6 single configuration write
    wr(2'd1, cfg(20, 10, 1, 1, 0));
    rd(2'd1, v); chk("R6 cfg stored", v, cfg(20, 10, 1, 1, 0));
    rd(2'd3, v); chk("R6 count loaded", v, 20);
    wr(2'd1, cfg(3, 31, 0, 0, 1));
    rd(2'd1, v); chk("R6 locked", v, cfg(20, 10, 1, 1, 0));
    rd(2'd3, v); chk("R6 count untouched", v, 20);
    ec = 20;

    // R4/R5 window sweep
    for (int c = 0; c <= 20; c++) begin
      if (ec > 10) begin pulse(DIV * (ec - 10)); ec = 10; end
      wr(2'd0, RESTART); ec = 20;
      pulse(DIV * (20 - c)); ec = c;
      rd(2'd2, v);
      base = nreq;
      wr(2'd0, RESTART);
      rd(2'd2, v);
      if (c > 10) begin
        chk("R5 early restart flag", v, 2);
        chk("R5 early restart req", nreq - base, 1);
      end else begin
        chk("R4 window restart ok", v, 0);
        chk("R4 no req", nreq - base, 0);
        ec = 20;
      end
      rd(2'd3, v); chk("R4 window count", v, ec);
    end

    // R8 halt
    dbg_halt_i = 1'b1; pulse(40);
    rd(2'd3, v); chk("R8 halted", v, ec);
    dbg_halt_i = 1'b0; pulse(8);
    rd(2'd3, v); chk("R8 resumed", v, ec - 2);
    ec = ec - 2;
    base = nreq;
    pulse(DIV * (ec + 1));
    rd(2'd3, v); chk("R3 reload custom", v, 20);
    chk("R3 req custom", nreq - base, 1);

    // R7 disabled
    do_reset();
    rd(2'd1, v); chk("R6 unlocked by reset", v, cfg(MAXC, MAXC, 1, 0, 0));
    wr(2'd1, cfg(7, MAXC, 1, 0, 1));
    base = nreq;
    pulse(200);
    rd(2'd3, v); chk("R7 frozen", v, 7);
    wr(2'd0, 32'h0000_0001);
    rd(2'd2, v); chk("R7 cmd ignored", v, 0);
    chk("R7 no req", nreq - base, 0);

    // R10 reset request disabled
    do_reset();
    wr(2'd1, cfg(3, MAXC, 0, 0, 0));
    base = nreq;
    pulse(DIV * 4);
    rd(2'd3, v); chk("R10 count", v, 3);
    rd(2'd2, v); chk("R10 uf flag", v, 1);
    wr(2'd0, 32'h1100_0001);
    rd(2'd2, v); chk("R10 err flag", v, 2);
    chk("R10 no req", nreq - base, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule